// File: doc/BRIEF.md
# Shared-Target Port Arbiter for a Multi-Layer Bus Matrix

This block is one target-side port of a multi-layer bus matrix. Several initiator layers (`N_LAYERS`) may send beats to the same target. Each layer has its own address decoder. A beat whose address falls in this port's window is captured in that layer's one-entry input stage. An arbiter picks one held beat and a mux steers its address, control and write data to the target. A layer whose beat is waiting sees its ready held low until its beat is taken.

The layer request side and the target side are valid/ready streams. A layer beat counts as offered when its transfer type is NONSEQ or SEQ and the decoder matches. It is taken on a rising edge where `lyr_ready` is high. A layer that has offered a beat and seen ready low keeps the same beat on its pins. The target side offers a beat with `slv_valid`, and the beat transfers on an edge where `slv_ready` is also high. Until then the beat and the chosen layer stay fixed.

Responses carry no back-pressure. The target returns them in order with `slv_rsp_valid`, and the block routes each one to the layer that issued the oldest outstanding beat. The arbitration policy is chosen on the plain `arb_mode` pin, which may change only while reset is asserted.

Top module: `ahbx_slave_port`

## Requirements
- R1: A layer beat is captured only when its type is NONSEQ (2'b10) or SEQ (2'b11) and `(addr & MASK) == BASE`. IDLE (2'b00), BUSY (2'b01) and beats outside the window are dropped, leave `lyr_ready` high and never reach the target.
- R2: A beat taken from a layer is offered on the target side no earlier than the next cycle. Its address, write flag, write data and type arrive unchanged. Each layer's beats reach the target in the order that layer issued them.
- R3: While a layer's input stage holds a beat that is not transferring to the target in the current cycle, that layer's `lyr_ready` is low.
- R4: Once `slv_valid` is high with `slv_ready` low, the next cycle again has `slv_valid` high with the same type, address, write flag and write data.
- R5: With `arb_mode` = 0 (round-robin per beat), the search starts at the layer after the last one granted, and layer 0 is first after reset.
- R6: With `arb_mode` = 1 (round-robin per burst), the layer whose beat was last taken keeps the port while its next held beat is SEQ. A held NONSEQ beat, or no held beat, releases the port to round-robin.
- R7: With `arb_mode` = 2 (fixed priority), among held beats the lowest layer index is granted.
- R8: A response is routed to the layer that issued the oldest unanswered beat. Only that layer sees `lyr_rsp_valid`, its `lyr_rdata` and `lyr_rsp_err` copy the target's, and every other layer sees zeros.
- R9: At most `OUTST` beats are outstanding. When that many are unanswered, `slv_valid` stays low.
- R10: During and right after reset, every `lyr_ready` is high, and `slv_valid` and all `lyr_rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| arb_mode | input | 2 | 0 per-beat round-robin, 1 per-burst round-robin, 2 or 3 fixed priority |
| lyr_trans | input | 2*N_LAYERS | Per-layer transfer type |
| lyr_addr | input | AW*N_LAYERS | Per-layer address |
| lyr_write | input | N_LAYERS | Per-layer write flag |
| lyr_wdata | input | DW*N_LAYERS | Per-layer write data |
| lyr_ready | output | N_LAYERS | Per-layer ready for the offered beat |
| lyr_rsp_valid | output | N_LAYERS | Per-layer response strobe |
| lyr_rdata | output | DW*N_LAYERS | Per-layer read data, zero when not owner |
| lyr_rsp_err | output | N_LAYERS | Per-layer error flag |
| slv_valid | output | 1 | Beat offered to the target |
| slv_ready | input | 1 | Target accepts the beat |
| slv_trans | output | 2 | Type of the routed beat |
| slv_addr | output | AW | Address of the routed beat |
| slv_write | output | 1 | Write flag of the routed beat |
| slv_wdata | output | DW | Write data of the routed beat |
| slv_rsp_valid | input | 1 | Target returns a response |
| slv_rdata | input | DW | Target read data |
| slv_rsp_err | input | 1 | Target error flag |

## Verification
A beat taken from a layer on edge k appears on the target side at the earliest after edge k+1. The bench therefore matches target beats against per-layer expected queues at the handshake, without waiting a fixed number of cycles. Ready and response routing are combinational from the current state and the target's inputs, so they are sampled one time unit after the falling edge on which the bench drives the inputs. Grant order in each mode is checked as the sequence of layers seen at the target after a reset, compared with orders that a bench function computes.

// File: rtl/ahbx_pkg.sv
package ahbx_pkg;
  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    ARB_RR_BEAT  = 2'd0,
    ARB_RR_BURST = 2'd1,
    ARB_FIXED    = 2'd2,
    ARB_FIXED_X  = 2'd3
  } arb_mode_e;
endpackage

// File: rtl/ahbx_in_stage.sv
module ahbx_in_stage #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [AW-1:0] MASK = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    in_trans,
  input  logic [AW-1:0] in_addr,
  input  logic          in_write,
  input  logic [DW-1:0] in_wdata,
  output logic          in_ready,
  input  logic          take,
  output logic          hold_vld,
  output logic [1:0]    hold_trans,
  output logic [AW-1:0] hold_addr,
  output logic          hold_write,
  output logic [DW-1:0] hold_wdata
);
  logic hit;
  logic capture;

  // decoder: active transfer type and address inside this port's window
  assign hit      = in_trans[1] && ((in_addr & MASK) == BASE);
  assign in_ready = !hold_vld || take;
  assign capture  = in_ready && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld   <= 1'b0;
      hold_trans <= ahbx_pkg::TR_IDLE;
      hold_addr  <= '0;
      hold_write <= 1'b0;
      hold_wdata <= '0;
    end else if (capture) begin
      hold_vld   <= 1'b1;
      hold_trans <= in_trans;
      hold_addr  <= in_addr;
      hold_write <= in_write;
      hold_wdata <= in_wdata;
    end else if (take) begin
      hold_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/ahbx_arbiter.sv
module ahbx_arbiter #(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  seq,
  input  logic          present,
  input  logic          accept,
  output logic [IW-1:0] gnt_id,
  output logic          gnt_any
);
  logic [IW-1:0] ptr_q, lock_id_q, hold_id_q;
  logic          lock_q, hold_q;
  logic          is_burst, is_fix, lock_eff;
  logic [IW-1:0] rr_id, fx_id;
  logic          rr_hit;
  int            idx;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] v);
    if (v == IW'(N - 1)) return '0;
    return v + 1'b1;
  endfunction

  assign is_burst = (mode == ahbx_pkg::ARB_RR_BURST);
  assign is_fix   = (mode == ahbx_pkg::ARB_FIXED) || (mode == ahbx_pkg::ARB_FIXED_X);
  assign lock_eff = lock_q && is_burst && req[lock_id_q] && seq[lock_id_q];

  // rotating search starting at the pointer
  always_comb begin
    rr_hit = 1'b0;
    rr_id  = ptr_q;
    idx    = 0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!rr_hit && req[idx]) begin
        rr_hit = 1'b1;
        rr_id  = IW'(idx);
      end
    end
  end

  // lowest index wins
  always_comb begin
    fx_id = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) fx_id = IW'(k);
    end
  end

  always_comb begin
    if (hold_q) begin
      gnt_id  = hold_id_q;
      gnt_any = req[hold_id_q];
    end else if (lock_eff) begin
      gnt_id  = lock_id_q;
      gnt_any = 1'b1;
    end else if (is_fix) begin
      gnt_id  = fx_id;
      gnt_any = |req;
    end else begin
      gnt_id  = rr_id;
      gnt_any = rr_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      lock_q    <= 1'b0;
      lock_id_q <= '0;
      hold_q    <= 1'b0;
      hold_id_q <= '0;
    end else begin
      hold_q    <= present && !accept;
      hold_id_q <= gnt_id;
      if (accept) begin
        ptr_q     <= nxt(gnt_id);
        lock_q    <= is_burst;
        lock_id_q <= gnt_id;
      end else if (!lock_eff) begin
        lock_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ahbx_owner_fifo.sv
module ahbx_owner_fifo #(
  parameter int IW    = 2,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [IW-1:0] push_id,
  input  logic          pop,
  output logic [IW-1:0] head_id,
  output logic          full,
  output logic          empty
);
  logic [IW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign head_id = mem[rd_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wr_q] <= push_id;
        wr_q      <= inc(wr_q);
      end
      if (pop) rd_q <= inc(rd_q);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ahbx_slave_port.sv
module ahbx_slave_port #(
  parameter int N_LAYERS = 3,
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int OUTST = 4,
  parameter logic [AW-1:0] BASE = 16'h8000,
  parameter logic [AW-1:0] MASK = 16'hC000,
  localparam int IW = (N_LAYERS > 1) ? $clog2(N_LAYERS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             arb_mode,
  input  logic [2*N_LAYERS-1:0]  lyr_trans,
  input  logic [AW*N_LAYERS-1:0] lyr_addr,
  input  logic [N_LAYERS-1:0]    lyr_write,
  input  logic [DW*N_LAYERS-1:0] lyr_wdata,
  output logic [N_LAYERS-1:0]    lyr_ready,
  output logic [N_LAYERS-1:0]    lyr_rsp_valid,
  output logic [DW*N_LAYERS-1:0] lyr_rdata,
  output logic [N_LAYERS-1:0]    lyr_rsp_err,
  output logic                   slv_valid,
  input  logic                   slv_ready,
  output logic [1:0]             slv_trans,
  output logic [AW-1:0]          slv_addr,
  output logic                   slv_write,
  output logic [DW-1:0]          slv_wdata,
  input  logic                   slv_rsp_valid,
  input  logic [DW-1:0]          slv_rdata,
  input  logic                   slv_rsp_err
);
  logic [N_LAYERS-1:0] held_vec, seq_vec, take_vec;
  logic [1:0]          h_trans [N_LAYERS];
  logic [AW-1:0]       h_addr  [N_LAYERS];
  logic                h_write [N_LAYERS];
  logic [DW-1:0]       h_wdata [N_LAYERS];
  logic [IW-1:0]       gnt_id, head_id;
  logic                gnt_any, accept, fifo_full, fifo_empty, pop;

  for (genvar g = 0; g < N_LAYERS; g++) begin : g_layer
    ahbx_in_stage #(.AW(AW), .DW(DW), .BASE(BASE), .MASK(MASK)) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_trans   (lyr_trans[2*g +: 2]),
      .in_addr    (lyr_addr[AW*g +: AW]),
      .in_write   (lyr_write[g]),
      .in_wdata   (lyr_wdata[DW*g +: DW]),
      .in_ready   (lyr_ready[g]),
      .take       (take_vec[g]),
      .hold_vld   (held_vec[g]),
      .hold_trans (h_trans[g]),
      .hold_addr  (h_addr[g]),
      .hold_write (h_write[g]),
      .hold_wdata (h_wdata[g])
    );
    assign seq_vec[g]  = (h_trans[g] == ahbx_pkg::TR_SEQ);
    assign take_vec[g] = accept && (gnt_id == IW'(g));

    // response return only to the owner of the oldest outstanding beat
    assign lyr_rsp_valid[g]        = pop && (head_id == IW'(g));
    assign lyr_rdata[DW*g +: DW]   = lyr_rsp_valid[g] ? slv_rdata : '0;
    assign lyr_rsp_err[g]          = lyr_rsp_valid[g] && slv_rsp_err;
  end

  ahbx_arbiter #(.N(N_LAYERS)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (arb_mode),
    .req     (held_vec),
    .seq     (seq_vec),
    .present (slv_valid),
    .accept  (accept),
    .gnt_id  (gnt_id),
    .gnt_any (gnt_any)
  );

  assign slv_valid = gnt_any && !fifo_full;
  assign accept    = slv_valid && slv_ready;
  assign pop       = slv_rsp_valid && !fifo_empty;

  always_comb begin
    if (gnt_any) begin
      slv_trans = h_trans[gnt_id];
      slv_addr  = h_addr[gnt_id];
      slv_write = h_write[gnt_id];
      slv_wdata = h_wdata[gnt_id];
    end else begin
      slv_trans = ahbx_pkg::TR_IDLE;
      slv_addr  = '0;
      slv_write = 1'b0;
      slv_wdata = '0;
    end
  end

  ahbx_owner_fifo #(.IW(IW), .DEPTH(OUTST)) u_own (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (accept),
    .push_id (gnt_id),
    .pop     (pop),
    .head_id (head_id),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );
endmodule

// File: rtl/ahbx_slave_port_chk.sv
module ahbx_slave_port_chk #(
  parameter int N_LAYERS = 3,
  parameter int AW = 16,
  parameter int OUTST = 4,
  parameter logic [AW-1:0] BASE = 16'h8000,
  parameter logic [AW-1:0] MASK = 16'hC000,
  parameter int DW = 16,
  localparam int IW = (N_LAYERS > 1) ? $clog2(N_LAYERS) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             arb_mode,
  input logic [2*N_LAYERS-1:0]  lyr_trans,
  input logic [AW*N_LAYERS-1:0] lyr_addr,
  input logic [N_LAYERS-1:0]    lyr_ready,
  input logic [N_LAYERS-1:0]    lyr_rsp_valid,
  input logic                   slv_valid,
  input logic                   slv_ready,
  input logic [1:0]             slv_trans,
  input logic [AW-1:0]          slv_addr,
  input logic                   slv_write,
  input logic [DW-1:0]          slv_wdata,
  input logic                   slv_rsp_valid,
  input logic [N_LAYERS-1:0]    held_vec,
  input logic [N_LAYERS-1:0]    seq_vec,
  input logic [IW-1:0]          gnt_id
);
  int outst_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst_cnt <= 0;
    else outst_cnt <= outst_cnt + ((slv_valid && slv_ready) ? 1 : 0) - ((|lyr_rsp_valid) ? 1 : 0);
  end

  p_payload_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_valid && !slv_ready) |=> (slv_valid && $stable(slv_trans) && $stable(slv_addr)
                                   && $stable(slv_write) && $stable(slv_wdata)));

  p_rsp_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|lyr_rsp_valid) |-> (slv_rsp_valid && $onehot(lyr_rsp_valid)));

  p_outst_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (outst_cnt <= OUTST) && ((outst_cnt == OUTST) -> !slv_valid));

  for (genvar g = 0; g < N_LAYERS; g++) begin : g_chk
    localparam int NX = (g + 1) % N_LAYERS;
    logic hit;
    assign hit = lyr_trans[2*g+1] && ((lyr_addr[AW*g +: AW] & MASK) == BASE);

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lyr_ready[g] && hit) |=> held_vec[g]);

    p_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !held_vec[g]) |=> !held_vec[g]);

    p_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_mode[1] && slv_valid && !$past(slv_valid && !slv_ready) && held_vec[g])
      |-> (gnt_id <= IW'(g)));

    p_burst_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_mode == 2'd1 && slv_valid && slv_ready && gnt_id == IW'(g))
      |=> (!(held_vec[g] && seq_vec[g]) || gnt_id == IW'(g)));

    p_rr_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_mode == 2'd0 && slv_valid && slv_ready && gnt_id == IW'(g))
      |=> (!held_vec[NX] || gnt_id == IW'(NX)));
  end
endmodule

bind ahbx_slave_port ahbx_slave_port_chk #(
  .N_LAYERS(N_LAYERS), .AW(AW), .OUTST(OUTST), .BASE(BASE), .MASK(MASK), .DW(DW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .arb_mode      (arb_mode),
  .lyr_trans     (lyr_trans),
  .lyr_addr      (lyr_addr),
  .lyr_ready     (lyr_ready),
  .lyr_rsp_valid (lyr_rsp_valid),
  .slv_valid     (slv_valid),
  .slv_ready     (slv_ready),
  .slv_trans     (slv_trans),
  .slv_addr      (slv_addr),
  .slv_write     (slv_write),
  .slv_wdata     (slv_wdata),
  .slv_rsp_valid (slv_rsp_valid),
  .held_vec      (held_vec),
  .seq_vec       (seq_vec),
  .gnt_id        (gnt_id)
);

// File: tb/tb_ahbx_slave_port.sv
module tb_ahbx_slave_port;
  localparam int N = 3, AW = 16, DW = 16, OUTST = 4;

  typedef struct packed {
    logic [1:0]    tr;
    logic [AW-1:0] a;
    logic          w;
    logic [DW-1:0] d;
  } beat_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] arb_mode = 2'd0;
  logic [2*N-1:0] lyr_trans = '0;
  logic [AW*N-1:0] lyr_addr = '0;
  logic [N-1:0] lyr_write = '0;
  logic [DW*N-1:0] lyr_wdata = '0;
  logic [N-1:0] lyr_ready, lyr_rsp_valid, lyr_rsp_err;
  logic [DW*N-1:0] lyr_rdata;
  logic slv_valid, slv_write;
  logic slv_ready = 1'b0, slv_rsp_valid = 1'b0, slv_rsp_err = 1'b0;
  logic [1:0] slv_trans;
  logic [AW-1:0] slv_addr;
  logic [DW-1:0] slv_wdata;
  logic [DW-1:0] slv_rdata = '0;

  always #4 clk = ~clk;

  ahbx_slave_port #(.N_LAYERS(N), .AW(AW), .DW(DW), .OUTST(OUTST)) dut (.*);

  beat_t src_q [N][$];
  beat_t exp_q [N][$];
  beat_t acc_q [$];
  int    slv_log [$];
  bit    l_pres [N];
  bit    l_hs [N];
  bit    s_hs, r_hs, s_stall;
  beat_t s_cur, s_prev;
  int    pres_pct = 100, rdy_pct = 100, rsp_pct = 100;
  bit    rsp_en = 1'b1;
  int    n_chk = 0, n_bad = 0;
  bit    finished = 1'b0;

  function automatic bit passes(beat_t b);
    return b.tr[1] && (b.a[15:14] == 2'b10);
  endfunction

  function automatic logic [DW-1:0] rsp_fn(logic [AW-1:0] a);
    return {a[7:0], ~a[15:8]} ^ 16'h5a5a;
  endfunction

  function automatic int exp_layer(int mode, int k);
    if (mode == 0) return k % 3;
    return k / 2;
  endfunction

  function automatic beat_t mk(logic [1:0] tr, int lyr, int n, bit hitw);
    beat_t b;
    b.tr = tr;
    b.a  = {hitw ? 2'b10 : 2'b00, 2'(lyr), 12'(n)};
    b.w  = n[0];
    b.d  = 16'(n * 7 + lyr * 4099);
    return b;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic step();
    int own;
    beat_t b;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      if (l_pres[i] && l_hs[i]) begin
        b = src_q[i].pop_front();
        if (passes(b)) exp_q[i].push_back(b);
      end
    end
    if (s_hs) begin
      own = int'(s_cur.a[13:12]);
      if (exp_q[own].size() == 0) chk(1'b0, "R2", s_cur, 0);
      else begin
        chk(exp_q[own][0] == s_cur, "R2", s_cur, exp_q[own][0]);
        exp_q[own].delete(0);
      end
      slv_log.push_back(own);
      acc_q.push_back(s_cur);
    end
    if (r_hs) acc_q.delete(0);
    for (int i = 0; i < N; i++) begin
      if (!(l_pres[i] && !l_hs[i]))
        l_pres[i] = (src_q[i].size() > 0) && (($urandom % 100) < pres_pct);
      if (l_pres[i]) begin
        b = src_q[i][0];
        lyr_trans[2*i +: 2] = b.tr;
        lyr_addr[AW*i +: AW] = b.a;
        lyr_write[i] = b.w;
        lyr_wdata[DW*i +: DW] = b.d;
      end else begin
        lyr_trans[2*i +: 2] = 2'b00;
        lyr_addr[AW*i +: AW] = 16'($urandom);
      end
    end
    slv_ready = (($urandom % 100) < rdy_pct);
    r_hs = rsp_en && (acc_q.size() > 0) && (($urandom % 100) < rsp_pct);
    slv_rsp_valid = r_hs;
    slv_rdata = r_hs ? rsp_fn(acc_q[0].a) : 16'($urandom);
    slv_rsp_err = r_hs ? (acc_q[0].a[0] ^ acc_q[0].a[4]) : 1'b0;
    #1;
    for (int i = 0; i < N; i++) l_hs[i] = lyr_ready[i];
    s_cur = '{tr: slv_trans, a: slv_addr, w: slv_write, d: slv_wdata};
    if (s_stall) chk(slv_valid && s_cur == s_prev, "R4", {slv_valid, s_cur}, {1'b1, s_prev});
    s_hs = slv_valid && slv_ready;
    s_stall = slv_valid && !slv_ready;
    s_prev = s_cur;
    if (r_hs) begin
      own = int'(acc_q[0].a[13:12]);
      for (int i = 0; i < N; i++) begin
        logic [DW:0] got, want;
        got  = {lyr_rsp_valid[i], lyr_rdata[DW*i +: DW]};
        want = (i == own) ? {1'b1, rsp_fn(acc_q[0].a)} : '0;
        chk(got == want && lyr_rsp_err[i] == (i == own && slv_rsp_err), "R8", got, want);
      end
    end
  endtask

  task automatic do_reset(int mode);
    @(negedge clk);
    rst_n = 1'b0;
    arb_mode = 2'(mode);
    lyr_trans = '0;
    slv_ready = 1'b0;
    slv_rsp_valid = 1'b0;
    for (int i = 0; i < N; i++) begin
      src_q[i].delete(); exp_q[i].delete(); l_pres[i] = 0; l_hs[i] = 0;
    end
    acc_q.delete(); slv_log.delete();
    s_hs = 0; r_hs = 0; s_stall = 0;
    repeat (2) @(negedge clk);
    #1;
    chk(lyr_ready == '1 && !slv_valid && lyr_rsp_valid == '0, "R10",
        {lyr_ready, slv_valid, lyr_rsp_valid}, {3'b111, 1'b0, 3'b000});
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(lyr_ready == '1 && !slv_valid, "R10", {lyr_ready, slv_valid}, {3'b111, 1'b0});
  endtask

  task automatic drain(string req);
    int guard = 0;
    bit busy = 1'b1;
    while (busy && guard < 5000) begin
      step();
      guard++;
      busy = acc_q.size() > 0 || s_hs;
      for (int i = 0; i < N; i++) busy = busy || src_q[i].size() > 0 || exp_q[i].size() > 0;
    end
    chk(!busy, req, guard, 0);
  endtask

  task automatic run_order(int mode, string req);
    do_reset(mode);
    pres_pct = 100; rdy_pct = 100; rsp_pct = 100; rsp_en = 1;
    for (int i = 0; i < N; i++) begin
      src_q[i].push_back(mk(2'b10, i, 1, 1));
      src_q[i].push_back(mk(2'b11, i, 2, 1));
    end
    step();
    chk(lyr_ready == 3'b111 && !slv_valid, "R2", {lyr_ready, slv_valid}, {3'b111, 1'b0});
    step();
    chk(lyr_ready == 3'b001, "R3", lyr_ready, 3'b001);
    repeat (10) step();
    chk(slv_log.size() == 6, req, slv_log.size(), 6);
    for (int k = 0; k < 6 && k < slv_log.size(); k++)
      chk(slv_log[k] == exp_layer(mode, k), req, slv_log[k], exp_layer(mode, k));
    drain(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    // per-mode grant order
    run_order(0, "R5");
    run_order(1, "R6");
    run_order(2, "R7");

    // R6: a fresh NONSEQ from the lock owner releases the port
    do_reset(1);
    src_q[0].push_back(mk(2'b10, 0, 1, 1));
    src_q[0].push_back(mk(2'b10, 0, 2, 1));
    src_q[1].push_back(mk(2'b10, 1, 1, 1));
    repeat (8) step();
    chk(slv_log.size() == 3, "R6", slv_log.size(), 3);
    if (slv_log.size() == 3)
      chk(slv_log[0] == 0 && slv_log[1] == 1 && slv_log[2] == 0, "R6",
          {slv_log[0], slv_log[1], slv_log[2]}, {32'd0, 32'd1, 32'd0});
    drain("R6");

    // R1: IDLE, BUSY and out-of-window beats are dropped
    do_reset(0);
    src_q[1].push_back(mk(2'b10, 1, 5, 0));
    src_q[1].push_back(mk(2'b01, 1, 6, 1));
    src_q[1].push_back(mk(2'b00, 1, 7, 1));
    src_q[1].push_back(mk(2'b11, 1, 8, 0));
    repeat (4) begin
      step();
      chk(lyr_ready[1] && !slv_valid, "R1", {lyr_ready[1], slv_valid}, 2'b10);
    end
    repeat (3) step();
    chk(slv_log.size() == 0 && !slv_valid, "R1", slv_log.size(), 0);

    // R9: outstanding limit with a silent target
    do_reset(0);
    rsp_en = 0;
    for (int n = 0; n < 6; n++) src_q[0].push_back(mk(2'b10, 0, n, 1));
    repeat (12) step();
    chk(slv_log.size() == OUTST, "R9", slv_log.size(), OUTST);
    chk(!slv_valid && !lyr_ready[0], "R9", {slv_valid, lyr_ready[0]}, 2'b00);
    rsp_en = 1;
    drain("R9");

    // constrained random traffic in every mode
    for (int m = 0; m < 3; m++) begin
      do_reset(m);
      pres_pct = 70; rdy_pct = 60; rsp_pct = 50;
      for (int i = 0; i < N; i++) begin
        int n = 0;
        while (n < 60) begin
          int len = 1 + int'($urandom % 4);
          for (int k = 0; k < len; k++) begin
            bit hitw = ($urandom % 10) != 0;
            logic [1:0] tr = (k == 0) ? 2'b10 : 2'b11;
            if (($urandom % 12) == 0) tr = 2'b01;
            src_q[i].push_back(mk(tr, i, n, hitw));
            n++;
          end
        end
      end
      drain("R2");
    end
    summary();
  end
endmodule